// File: doc/BRIEF.md
# Retry and Deadlock-Escape Request Controller

This block sits on the request side of a node in a directory-coherent system. It holds a few outstanding coherence requests, each in its own slot, and sends them into the network one per cycle. A busy target answers with a negative acknowledgement (NAK) rather than queueing the request. The slot then backs off for a fixed number of cycles and sends the request again. A positive answer, either a plain acknowledgement or a data reply, frees the slot.

Each slot has an age counter. It starts when the slot is allocated and keeps running through every retry. When any slot's age reaches the timeout limit, the node moves from the `MD_NORMAL` mode state to the `MD_MITIGATE` mode state. In that mode, foreign requests that would spawn further requests are refused, while terminal operations such as writebacks are still accepted so that they can drain. The node returns to `MD_NORMAL` once every slot has been freed by a positive response.

Each slot runs its own state machine with four states. `SL_FREE` moves to `SL_ISSUE` when the slot is allocated. `SL_ISSUE` moves to `SL_WAIT` when the slot wins the send port. From `SL_WAIT`, a positive response moves the slot back to `SL_FREE`, and a NAK moves it to `SL_BACKOFF`. `SL_BACKOFF` moves to `SL_ISSUE` when its delay count runs out.

Top module: `nak_retry_ctrl`

## Requirements
- R1: `req_accept` is high in the same cycle as `req_valid` whenever a slot is in `SL_FREE`, and the request goes into the free slot with the lowest index. When all DEPTH slots are occupied, `req_accept` is low and the request is dropped.
- R2: A newly allocated slot is offered on `send_valid`/`send_slot`/`send_addr` in the cycle after its allocating clock edge. Only one slot is sent per cycle, and the lowest-index slot in `SL_ISSUE` wins.
- R3: A NAK (`rsp_kind` = 2'b01) addressed by `rsp_slot` to a slot in `SL_WAIT` puts the slot into `SL_BACKOFF`. The slot is not sent for RETRY_DLY cycles and is offered again in the cycle after that.
- R4: An ACK (`rsp_kind` = 2'b00) or a DATA reply (`rsp_kind` = 2'b10) to a slot in `SL_WAIT` frees the slot and clears its age. The freed slot can be allocated again.
- R5: A slot's age counts every clock edge from its allocation and is not reset by NAKs. `mit_mode` rises on the (TIMEOUT+1)th clock edge after the allocating edge of a slot that is still pending.
- R6: In `MD_MITIGATE`, a foreign request with `fgn_gen` = 1 raises `fgn_refuse`, and one with `fgn_gen` = 0 raises `fgn_accept`. In `MD_NORMAL`, every foreign request is accepted. With `fgn_valid` low, both outputs are low.
- R7: `MD_MITIGATE` holds while any slot is occupied. `mit_mode` falls one clock edge after the edge on which the last slot is freed.
- R8: After reset, all slots are free, `send_valid` is low and `mit_mode` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | New local request offered |
| req_addr | input | ADDR_W | Line address of the new request |
| req_accept | output | 1 | New request taken into a slot |
| send_valid | output | 1 | A request is being sent this cycle |
| send_slot | output | SLOT_W | Slot index of the request being sent |
| send_addr | output | ADDR_W | Line address of the request being sent |
| rsp_valid | input | 1 | Response arriving |
| rsp_slot | input | SLOT_W | Slot the response belongs to |
| rsp_kind | input | 2 | 00 ACK, 01 NAK, 10 DATA, 11 ignored |
| fgn_valid | input | 1 | Foreign request arriving |
| fgn_gen | input | 1 | 1: foreign request would generate more requests; 0: terminal |
| fgn_accept | output | 1 | Foreign request accepted |
| fgn_refuse | output | 1 | Foreign request refused |
| mit_mode | output | 1 | Deadlock-mitigation mode active |

## Verification
The assertions check on every cycle that:
- a full buffer refuses new work;
- a NAK always lands a waiting slot in back-off;
- a positive answer always frees the slot and zeroes its age;
- an expired age always forces mitigation;
- mitigation never ends while a slot is occupied;
- accept and refuse are exclusive.

The bench scenarios show the things a per-cycle property cannot express:
- the exact length of the back-off window;
- the exact edge on which escalation and exit happen;
- that a NAK midway does not restart the age count;
- which slot index is reused after a DATA reply.

// File: rtl/nrc_pkg.sv
package nrc_pkg;

    typedef enum logic [1:0] {
        SL_FREE    = 2'd0,
        SL_ISSUE   = 2'd1,
        SL_WAIT    = 2'd2,
        SL_BACKOFF = 2'd3
    } slot_st_e;

    typedef enum logic [1:0] {
        RSP_ACK  = 2'b00,
        RSP_NAK  = 2'b01,
        RSP_DATA = 2'b10,
        RSP_RSVD = 2'b11
    } rsp_kind_e;

    typedef enum logic {
        MD_NORMAL   = 1'b0,
        MD_MITIGATE = 1'b1
    } mode_e;

endpackage

// File: rtl/nrc_pick.sv
module nrc_pick #(
    parameter int N     = 4,
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]     vec_i,
    output logic             found_o,
    output logic [IDX_W-1:0] idx_o,
    output logic [N-1:0]     onehot_o
);
    // Lowest set bit wins: the scan runs downward so the last hit is the lowest.
    always_comb begin
        found_o  = 1'b0;
        idx_o    = '0;
        onehot_o = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec_i[i]) begin
                found_o = 1'b1;
                idx_o   = IDX_W'(i);
            end
        end
        if (found_o) onehot_o[idx_o] = 1'b1;
    end

endmodule

// File: rtl/nrc_slot.sv
module nrc_slot
    import nrc_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int TIMEOUT   = 256,
    parameter int RETRY_DLY = 4,
    localparam int AGE_W    = $clog2(TIMEOUT + 1),
    localparam int BK_W     = $clog2(RETRY_DLY + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alloc_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              grant_i,
    input  logic              rsp_hit_i,
    input  logic [1:0]        rsp_kind_i,
    output logic              free_o,
    output logic              issue_o,
    output logic              expired_o,
    output logic [ADDR_W-1:0] addr_o
);
    slot_st_e          st_q, st_d;
    logic [AGE_W-1:0]  age_q;
    logic [BK_W-1:0]   bk_q;
    logic [ADDR_W-1:0] addr_q;
    logic              pos_rsp, nak_rsp;

    assign pos_rsp = rsp_hit_i && (rsp_kind_i == RSP_ACK || rsp_kind_i == RSP_DATA);
    assign nak_rsp = rsp_hit_i && (rsp_kind_i == RSP_NAK);

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= SL_FREE;
        else        st_q <= st_d;
    end

    // Transitions
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            SL_FREE:    if (alloc_i) st_d = SL_ISSUE;
            SL_ISSUE:   if (grant_i) st_d = SL_WAIT;
            SL_WAIT: begin
                if (pos_rsp)      st_d = SL_FREE;
                else if (nak_rsp) st_d = SL_BACKOFF;
            end
            SL_BACKOFF: if (bk_q <= BK_W'(1)) st_d = SL_ISSUE;
            default:    st_d = SL_FREE;
        endcase
    end

    // Outputs
    always_comb begin
        free_o  = 1'b0;
        issue_o = 1'b0;
        unique case (st_q)
            SL_FREE:    free_o  = 1'b1;
            SL_ISSUE:   issue_o = 1'b1;
            SL_WAIT:    ;
            SL_BACKOFF: ;
            default:    ;
        endcase
    end

    assign expired_o = (age_q == AGE_W'(TIMEOUT));
    assign addr_o    = addr_q;

    // Age spans all retries; saturates at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            age_q <= '0;
        end else if (st_d == SL_FREE) begin
            age_q <= '0;
        end else if (st_q != SL_FREE && !expired_o) begin
            age_q <= age_q + AGE_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bk_q <= '0;
        end else if (st_q == SL_WAIT && nak_rsp && !pos_rsp) begin
            bk_q <= BK_W'(RETRY_DLY);
        end else if (st_q == SL_BACKOFF && bk_q != '0) begin
            bk_q <= bk_q - BK_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)                       addr_q <= '0;
        else if (st_q == SL_FREE && alloc_i) addr_q <= addr_i;
    end

    AST_NAK_HOLDS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == SL_WAIT && nak_rsp) |=> (st_q == SL_BACKOFF && !issue_o)); // R3

    AST_POS_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == SL_WAIT && pos_rsp) |=> (free_o && age_q == '0)); // R4

endmodule

// File: rtl/nrc_mode.sv
module nrc_mode
    import nrc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic any_expired_i,
    input  logic all_free_i,
    input  logic fgn_valid_i,
    input  logic fgn_gen_i,
    output logic mit_o,
    output logic fgn_accept_o,
    output logic fgn_refuse_o
);
    mode_e md_q, md_d;

    always_ff @(posedge clk) begin
        if (!rst_n) md_q <= MD_NORMAL;
        else        md_q <= md_d;
    end

    always_comb begin
        md_d = md_q;
        unique case (md_q)
            MD_NORMAL:   if (any_expired_i) md_d = MD_MITIGATE;
            MD_MITIGATE: if (!any_expired_i && all_free_i) md_d = MD_NORMAL;
            default:     md_d = MD_NORMAL;
        endcase
    end

    always_comb begin
        mit_o        = 1'b0;
        fgn_accept_o = 1'b0;
        fgn_refuse_o = 1'b0;
        unique case (md_q)
            MD_NORMAL: fgn_accept_o = fgn_valid_i;
            MD_MITIGATE: begin
                mit_o        = 1'b1;
                fgn_accept_o = fgn_valid_i && !fgn_gen_i;
                fgn_refuse_o = fgn_valid_i && fgn_gen_i;
            end
            default: ;
        endcase
    end

    AST_ENTER_ON_EXPIRY: assert property (@(posedge clk) disable iff (!rst_n)
        any_expired_i |=> (md_q == MD_MITIGATE)); // R5

    AST_STAY_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (md_q == MD_MITIGATE && !all_free_i) |=> (md_q == MD_MITIGATE)); // R7

endmodule

// File: rtl/nak_retry_ctrl.sv
module nak_retry_ctrl
    import nrc_pkg::*;
#(
    parameter int DEPTH     = 4,
    parameter int ADDR_W    = 16,
    parameter int TIMEOUT   = 256,
    parameter int RETRY_DLY = 4,
    localparam int SLOT_W   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              req_accept,
    output logic              send_valid,
    output logic [SLOT_W-1:0] send_slot,
    output logic [ADDR_W-1:0] send_addr,
    input  logic              rsp_valid,
    input  logic [SLOT_W-1:0] rsp_slot,
    input  logic [1:0]        rsp_kind,
    input  logic              fgn_valid,
    input  logic              fgn_gen,
    output logic              fgn_accept,
    output logic              fgn_refuse,
    output logic              mit_mode
);
    logic [DEPTH-1:0]  free_v, issue_v, expired_v, alloc_v, grant_v, free_oh, issue_oh;
    logic [ADDR_W-1:0] slot_addr [DEPTH];
    logic              any_free, any_issue;
    logic [SLOT_W-1:0] free_idx, issue_idx;

    nrc_pick #(.N(DEPTH)) i_free_pick (
        .vec_i(free_v), .found_o(any_free), .idx_o(free_idx), .onehot_o(free_oh)
    );

    nrc_pick #(.N(DEPTH)) i_issue_pick (
        .vec_i(issue_v), .found_o(any_issue), .idx_o(issue_idx), .onehot_o(issue_oh)
    );

    assign req_accept = req_valid && any_free;
    assign alloc_v    = req_valid ? free_oh : '0;
    assign grant_v    = issue_oh;
    assign send_valid = any_issue;
    assign send_slot  = issue_idx;
    assign send_addr  = slot_addr[issue_idx];

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        nrc_slot #(
            .ADDR_W(ADDR_W), .TIMEOUT(TIMEOUT), .RETRY_DLY(RETRY_DLY)
        ) i_slot (
            .clk       (clk),
            .rst_n     (rst_n),
            .alloc_i   (alloc_v[g]),
            .addr_i    (req_addr),
            .grant_i   (grant_v[g]),
            .rsp_hit_i (rsp_valid && rsp_slot == SLOT_W'(g)),
            .rsp_kind_i(rsp_kind),
            .free_o    (free_v[g]),
            .issue_o   (issue_v[g]),
            .expired_o (expired_v[g]),
            .addr_o    (slot_addr[g])
        );
    end

    nrc_mode i_mode (
        .clk          (clk),
        .rst_n        (rst_n),
        .any_expired_i(|expired_v),
        .all_free_i   (&free_v),
        .fgn_valid_i  (fgn_valid),
        .fgn_gen_i    (fgn_gen),
        .mit_o        (mit_mode),
        .fgn_accept_o (fgn_accept),
        .fgn_refuse_o (fgn_refuse)
    );

    AST_FULL_REFUSE: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && free_v == '0) |-> !req_accept); // R1

    AST_SEND_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        send_valid |-> ($onehot(grant_v) && issue_v[send_slot])); // R2

    AST_FGN_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        fgn_valid |-> (fgn_accept ^ fgn_refuse)); // R6

endmodule

// File: tb/test_nak_retry_ctrl.sv
module test_nak_retry_ctrl;
    localparam int DEPTH = 4;
    localparam int ADDR_W = 8;
    localparam int TMO = 40;
    localparam int DLY = 3;
    localparam int SW = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic req_accept, send_valid;
    logic [SW-1:0] send_slot;
    logic [ADDR_W-1:0] send_addr;
    logic rsp_valid = 1'b0;
    logic [SW-1:0] rsp_slot = '0;
    logic [1:0] rsp_kind = 2'b00;
    logic fgn_valid = 1'b0, fgn_gen = 1'b0;
    logic fgn_accept, fgn_refuse, mit_mode;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    nak_retry_ctrl #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .TIMEOUT(TMO), .RETRY_DLY(DLY)) i_nak_retry_ctrl (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_accept(req_accept), .send_valid(send_valid), .send_slot(send_slot),
        .send_addr(send_addr), .rsp_valid(rsp_valid), .rsp_slot(rsp_slot),
        .rsp_kind(rsp_kind), .fgn_valid(fgn_valid), .fgn_gen(fgn_gen),
        .fgn_accept(fgn_accept), .fgn_refuse(fgn_refuse), .mit_mode(mit_mode)
    );

    // Foreign-request table: {in_mitigation, fgn_valid, fgn_gen, exp_accept, exp_refuse}
    localparam logic [4:0] FGN_TAB [6] = '{
        5'b0_0_0_0_0, 5'b0_1_0_1_0, 5'b0_1_1_1_0,
        5'b1_0_1_0_0, 5'b1_1_1_0_1, 5'b1_1_0_1_0
    };

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic respond(input int slot, input logic [1:0] kind);
        rsp_valid = 1'b1; rsp_slot = SW'(slot); rsp_kind = kind;
        tick();
        rsp_valid = 1'b0;
    endtask

    task automatic run_fgn(input bit mit);
        for (int i = 0; i < 6; i++) begin
            if (FGN_TAB[i][4] == mit) begin
                fgn_valid = FGN_TAB[i][3];
                fgn_gen   = FGN_TAB[i][2];
                #1;
                chk("R6 accept", int'(fgn_accept), int'(FGN_TAB[i][1]));
                chk("R6 refuse", int'(fgn_refuse), int'(FGN_TAB[i][0]));
                tick();
            end
        end
        fgn_valid = 1'b0;
        fgn_gen   = 1'b0;
    endtask

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        // R8 reset state
        chk("R8 send_valid", int'(send_valid), 0);
        chk("R8 mit_mode", int'(mit_mode), 0);
        run_fgn(1'b0);

        // R1/R2: fill all slots, one send per cycle in index order
        for (int k = 0; k < DEPTH; k++) begin
            req_valid = 1'b1; req_addr = ADDR_W'(8'h10 + k);
            #1;
            chk("R1 accept free slot", int'(req_accept), 1);
            if (k > 0) begin
                chk("R2 send_valid", int'(send_valid), 1);
                chk("R2 send_slot order", int'(send_slot), k - 1);
            end
            tick();
        end
        req_valid = 1'b1; req_addr = 8'h20;
        #1;
        chk("R1 full refuses", int'(req_accept), 0);
        chk("R2 last slot sent", int'(send_slot), 3);
        chk("R2 last addr", int'(send_addr), 8'h13);
        tick();
        req_valid = 1'b0;
        // R4: DATA frees slot 2
        respond(2, 2'b10);
        req_valid = 1'b1; req_addr = 8'h30;
        #1;
        chk("R4 freed slot reusable", int'(req_accept), 1);
        tick();
        req_valid = 1'b0;
        chk("R1 lowest free slot reused", int'(send_slot), 2);
        chk("R2 reused slot addr", int'(send_addr), 8'h30);
        tick();
        respond(0, 2'b00);
        respond(1, 2'b00);
        respond(3, 2'b00);
        respond(2, 2'b00);
        chk("R4 nothing pending to send", int'(send_valid), 0);
        chk("R5 no escalation when served", int'(mit_mode), 0);

        // R3: NAK back-off window
        req_valid = 1'b1; req_addr = 8'hA5;
        #1;
        chk("R4 all freed accept", int'(req_accept), 1);
        tick();
        req_valid = 1'b0;
        chk("R2 send next cycle", int'(send_valid), 1);
        chk("R4 freed slot 0 lowest", int'(send_slot), 0);
        tick();
        respond(0, 2'b01);
        for (int d = 1; d <= DLY; d++) begin
            chk("R3 quiet during back-off", int'(send_valid), 0);
            if (d < DLY) tick();
        end
        tick();
        chk("R3 resend after back-off", int'(send_valid), 1);
        chk("R3 resend addr", int'(send_addr), 8'hA5);
        tick();
        respond(0, 2'b10);
        chk("R4 data completes retry", int'(send_valid), 0);

        // R5/R6/R7: escalation, filtering, exit
        req_valid = 1'b1; req_addr = 8'h55;
        tick();                                 // t = 0
        req_addr = 8'h66;
        tick();                                 // t = 1 (slot0 waiting)
        req_valid = 1'b0;
        respond(0, 2'b01);                      // t = 2, NAK must not reset age
        repeat (TMO - 2) tick();                // t = TMO
        chk("R5 not yet escalated", int'(mit_mode), 0);
        tick();                                 // t = TMO+1
        chk("R5 escalated", int'(mit_mode), 1);
        run_fgn(1'b1);
        respond(0, 2'b00);
        chk("R7 stays while slot 1 busy", int'(mit_mode), 1);
        respond(1, 2'b00);
        chk("R7 one edge lag", int'(mit_mode), 1);
        tick();
        chk("R7 exits when empty", int'(mit_mode), 0);
        run_fgn(1'b0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule